// File: doc/BRIEF.md
# Two-wire memory slave engine

This block is the bit-level protocol engine of a two-wire serial memory with 2048 bytes, seen as eight blocks of 256 bytes. It works on SCL and SDA levels that have already been synchronised and filtered, and on START and STOP strobes that a front-end derives from them. Its only drive onto the bus is an open-drain pull-low enable for SDA. It decodes the control byte and captures the word address. Received data bytes go out on a single-cycle write port, which feeds a separate page buffer. Bytes to transmit are fetched from a read port of the array.

The engine holds the 11-bit address pointer. The three block-select bits of each control byte become bits 10:8 of that pointer, and the byte that follows a write control byte loads bits 7:0. The pointer advances after every byte that is written or transmitted, so current-address, random and sequential reads all work from it. An external busy input marks an internal programming cycle. While it is high the engine acknowledges nothing, which lets a master poll for completion.

Top module: `twmem_slave`

## Requirements
- R1: A control byte is acknowledged only if its bits 7:4 equal 4'b1010. The engine acknowledges by pulling SDA low through the whole ninth clock. When the code does not match, the engine gives no acknowledge and ignores every bus clock until the next START.
- R2: Bits 3:1 of an accepted control byte load address bits 10:8. Bit 0 selects the direction: 1 is a read, 0 is a write.
- R3: After a write control byte, the next byte loads address bits 7:0. Each later byte is acknowledged and sent out as a one-cycle write strobe carrying the current address. The pointer then advances by one.
- R4: While busy is high at the end of any received byte, including the control byte, the engine gives no acknowledge, issues no write strobe and returns to idle.
- R5: A read control byte with no preceding address byte transmits the byte at the pointer, which is the last accessed address plus one.
- R6: A write control byte and an address byte, followed by a repeated START and a read control byte, transmit the byte at the newly loaded address.
- R7: During a read, an acknowledge from the master after a byte makes the engine send the next address. A not-acknowledge makes it release SDA and stay released until START or STOP.
- R8: The pointer wraps from 0x7FF to 0x000 during a sequential read.
- R9: SDA is sampled on the rising edge of SCL, MSB first. The engine changes its SDA drive exactly HOLD_CYC+1 clocks after it sees SCL fall, and never while SCL stays high.
- R10: After reset, and after any START or STOP, SDA is released. A STOP in mid-byte returns the engine to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised, filtered SCL level |
| sda_i | input | 1 | Synchronised, filtered SDA level |
| start_i | input | 1 | One-cycle strobe for a START or repeated START |
| stop_i | input | 1 | One-cycle strobe for a STOP |
| busy_i | input | 1 | High while an internal programming cycle runs |
| sda_pull_o | output | 1 | 1 pulls SDA low; 0 releases it |
| wr_en_o | output | 1 | One-cycle strobe for a received data byte |
| wr_addr_o | output | BLK_W+8 | Address of the received data byte |
| wr_data_o | output | 8 | Received data byte |
| rd_addr_o | output | BLK_W+8 | Address pointer, presented to the array read port |
| rd_data_i | input | 8 | Array byte at rd_addr_o, valid one clock after the address |

## Verification
The bound checker watches timing and handshake rules on every cycle. It checks that the SDA drive moves only after the delayed SCL fall or a START or STOP, and that it holds still while SCL is high. It also checks that no acknowledge phase begins while busy is high, that write strobes last one cycle and only occur with busy low, and that the pointer sits one past each written address. Only the directed scenarios can show the data path. They cover which control codes get an acknowledge, where written bytes land, the data returned by current-address, random and sequential reads, the wrap at the top of memory, the released bus after a master not-acknowledge, and acknowledge polling across a busy period.

// File: rtl/twmem_pkg.sv
package twmem_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CTRL,
      ST_WADR,
      ST_WDAT,
      ST_ACK,
      ST_TX,
      ST_MACK,
      ST_WAIT
   } tw_state_e;

   localparam int BYTE_W = 8;

endpackage

// File: rtl/twmem_scl_edges.sv
module twmem_scl_edges (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   output logic rise_o,
   output logic fall_o
);

   logic scl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) scl_q <= 1'b1;
      else        scl_q <= scl_i;
   end

   assign rise_o = scl_i & ~scl_q;
   assign fall_o = scl_q & ~scl_i;

endmodule

// File: rtl/twmem_hold_dly.sv
module twmem_hold_dly #(
   parameter int HOLD_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fall_i,
   output logic upd_o
);

   generate
      if (HOLD_CYC == 0) begin : g_direct
         assign upd_o = fall_i;
      end else begin : g_line
         logic [HOLD_CYC-1:0] line_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               line_q <= '0;
            end else begin
               line_q[0] <= fall_i;
               for (int k = 1; k < HOLD_CYC; k++) line_q[k] <= line_q[k-1];
            end
         end
         assign upd_o = line_q[HOLD_CYC-1];
      end
   endgenerate

endmodule

// File: rtl/twmem_addr_ptr.sv
module twmem_addr_ptr #(
   parameter int BLK_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ld_blk_i,
   input  logic [BLK_W-1:0]   blk_i,
   input  logic               ld_lo_i,
   input  logic [7:0]         lo_i,
   input  logic               inc_i,
   output logic [BLK_W+7:0]   ptr_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_o <= '0;
      end else if (inc_i) begin
         ptr_o <= ptr_o + 1'b1;
      end else begin
         if (ld_blk_i) ptr_o[BLK_W+7:8] <= blk_i;
         if (ld_lo_i)  ptr_o[7:0]       <= lo_i;
      end
   end

endmodule

// File: rtl/twmem_slave.sv
module twmem_slave
   import twmem_pkg::*;
#(
   parameter int         BLK_W    = 3,
   parameter int         HOLD_CYC = 3,
   parameter logic [3:0] DEV_CODE = 4'b1010
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic             busy_i,
   output logic             sda_pull_o,
   output logic             wr_en_o,
   output logic [BLK_W+7:0] wr_addr_o,
   output logic [7:0]       wr_data_o,
   output logic [BLK_W+7:0] rd_addr_o,
   input  logic [7:0]       rd_data_i
);

   localparam int ADDR_W = BLK_W + BYTE_W;
   localparam int CNT_W  = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

   generate
      if (BLK_W < 1 || BLK_W > 8) begin : g_bad_blk
         $error("twmem_slave: BLK_W must lie in 1..8");
      end
      if (HOLD_CYC < 0 || HOLD_CYC > 16) begin : g_bad_hold
         $error("twmem_slave: HOLD_CYC must lie in 0..16");
      end
   endgenerate

   tw_state_e        state, nxt;
   logic [CNT_W-1:0] cnt;
   logic [7:0]       shreg;
   logic             more;
   logic             rise, fall, upd;
   logic             ld_blk, ld_lo, inc;
   logic [ADDR_W-1:0] ptr;
   logic             code_ok, byte_end, ack_phase;

   twmem_scl_edges u_edges (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .rise_o(rise), .fall_o(fall)
   );

   twmem_hold_dly #(.HOLD_CYC(HOLD_CYC)) u_hold (
      .clk(clk), .rst_n(rst_n), .fall_i(fall), .upd_o(upd)
   );

   twmem_addr_ptr #(.BLK_W(BLK_W)) u_ptr (
      .clk(clk), .rst_n(rst_n),
      .ld_blk_i(ld_blk), .blk_i(shreg[BLK_W:1]),
      .ld_lo_i(ld_lo), .lo_i(shreg),
      .inc_i(inc), .ptr_o(ptr)
   );

   assign rd_addr_o = ptr;
   assign code_ok   = (shreg[7:4] == DEV_CODE);
   assign byte_end  = upd && (cnt == FULL) && !start_i && !stop_i;
   assign ack_phase = (state == ST_ACK);

   // pointer side effects at the end of a byte
   always_comb begin
      ld_blk = 1'b0;
      ld_lo  = 1'b0;
      inc    = 1'b0;
      if (byte_end) begin
         case (state)
            ST_CTRL: ld_blk = code_ok && !busy_i;
            ST_WADR: ld_lo  = !busy_i;
            ST_WDAT: inc    = !busy_i;
            ST_TX:   inc    = 1'b1;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         nxt        <= ST_IDLE;
         cnt        <= '0;
         shreg      <= '0;
         more       <= 1'b0;
         sda_pull_o <= 1'b0;
         wr_en_o    <= 1'b0;
         wr_addr_o  <= '0;
         wr_data_o  <= '0;
      end else begin
         wr_en_o <= 1'b0;
         if (start_i) begin
            state      <= ST_CTRL;
            cnt        <= '0;
            sda_pull_o <= 1'b0;
         end else if (stop_i) begin
            state      <= ST_IDLE;
            sda_pull_o <= 1'b0;
         end else begin
            case (state)
               ST_CTRL, ST_WADR, ST_WDAT: begin
                  if (rise && cnt < FULL) begin
                     shreg <= {shreg[6:0], sda_i};
                     cnt   <= cnt + 1'b1;
                  end else if (byte_end) begin
                     cnt <= '0;
                     if (busy_i || (state == ST_CTRL && !code_ok)) begin
                        state <= ST_IDLE;
                     end else begin
                        sda_pull_o <= 1'b1;
                        state      <= ST_ACK;
                        if (state == ST_CTRL) begin
                           nxt <= shreg[0] ? ST_TX : ST_WADR;
                        end else begin
                           nxt <= ST_WDAT;
                        end
                        if (state == ST_WDAT) begin
                           wr_en_o   <= 1'b1;
                           wr_addr_o <= ptr;
                           wr_data_o <= shreg;
                        end
                     end
                  end
               end
               ST_ACK: begin
                  if (upd) begin
                     state <= nxt;
                     cnt   <= '0;
                     if (nxt == ST_TX) begin
                        shreg      <= rd_data_i;
                        sda_pull_o <= ~rd_data_i[7];
                     end else begin
                        sda_pull_o <= 1'b0;
                     end
                  end
               end
               ST_TX: begin
                  if (rise) begin
                     cnt <= cnt + 1'b1;
                  end else if (upd) begin
                     if (cnt == FULL) begin
                        sda_pull_o <= 1'b0;
                        state      <= ST_MACK;
                     end else begin
                        shreg      <= {shreg[6:0], 1'b0};
                        sda_pull_o <= ~shreg[6];
                     end
                  end
               end
               ST_MACK: begin
                  if (rise) begin
                     more <= ~sda_i;
                  end else if (upd) begin
                     if (more) begin
                        state      <= ST_TX;
                        cnt        <= '0;
                        shreg      <= rd_data_i;
                        sda_pull_o <= ~rd_data_i[7];
                     end else begin
                        state <= ST_WAIT;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/twmem_slave_chk.sv
module twmem_slave_chk #(
   parameter int ADDR_W = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_i,
   input logic              start_i,
   input logic              stop_i,
   input logic              busy_i,
   input logic              sda_pull_o,
   input logic              wr_en_o,
   input logic [ADDR_W-1:0] wr_addr_o,
   input logic [ADDR_W-1:0] rd_addr_o,
   input logic              upd,
   input logic              ack_phase
);

   // R4: an acknowledge phase never opens on a byte that ended while busy
   assert_busy_nack_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_phase) |-> !$past(busy_i));

   // R4: no write strobe comes from a byte that ended while busy
   assert_no_wr_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> !$past(busy_i));

   // R3: write strobe lasts one cycle
   assert_wr_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |=> !wr_en_o);

   // R3: pointer stands one past the byte just written
   assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> (rd_addr_o == ADDR_W'(wr_addr_o + 1'b1)));

   // R9: drive changes only after the delayed SCL fall or a bus condition
   assert_sda_timing_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_pull_o != $past(sda_pull_o)) |-> $past(upd || start_i || stop_i));

   // R9: drive holds still while SCL stays high
   assert_sda_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_i && $past(scl_i) && !$past(start_i) && !$past(stop_i)) |-> $stable(sda_pull_o));

   // R10: START or STOP releases the line
   assert_cond_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i || stop_i) |=> !sda_pull_o);

endmodule

bind twmem_slave twmem_slave_chk #(.ADDR_W(BLK_W + 8)) u_chk (
   .clk(clk),
   .rst_n(rst_n),
   .scl_i(scl_i),
   .start_i(start_i),
   .stop_i(stop_i),
   .busy_i(busy_i),
   .sda_pull_o(sda_pull_o),
   .wr_en_o(wr_en_o),
   .wr_addr_o(wr_addr_o),
   .rd_addr_o(rd_addr_o),
   .upd(upd),
   .ack_phase(ack_phase)
);

// File: tb/twmem_slave_tb.sv
module twmem_slave_tb;

   localparam int HOLD = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl = 1'b1;
   logic        m_sda = 1'b1;
   logic        start_s = 1'b0;
   logic        stop_s = 1'b0;
   logic        busy = 1'b0;
   logic        sda_pull;
   logic        sda_bus;
   logic        wr_en;
   logic [10:0] wr_addr;
   logic [7:0]  wr_data;
   logic [10:0] rd_addr;
   logic [7:0]  rd_data;
   logic [7:0]  mem [0:2047];

   int n_chk = 0;
   int n_bad = 0;
   int n_wr  = 0;
   int ack_lat = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   assign sda_bus = m_sda & ~sda_pull;
   assign rd_data = mem[rd_addr];

   twmem_slave #(.BLK_W(3), .HOLD_CYC(HOLD), .DEV_CODE(4'b1010)) u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
      .start_i(start_s), .stop_i(stop_s), .busy_i(busy),
      .sda_pull_o(sda_pull), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
      .wr_data_o(wr_data), .rd_addr_o(rd_addr), .rd_data_i(rd_data)
   );

   always @(posedge clk) begin
      if (wr_en) begin
         mem[wr_addr] <= wr_data;
         n_wr <= n_wr + 1;
      end
   end

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 37 + 11) ^ (a >> 3));
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; tick(5);
      scl = 1'b1;   tick(5);
      m_sda = 1'b0; start_s = 1'b1; tick(1);
      start_s = 1'b0; tick(4);
      scl = 1'b0;   tick(5);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; tick(5);
      scl = 1'b1;   tick(5);
      m_sda = 1'b1; stop_s = 1'b1; tick(1);
      stop_s = 1'b0; tick(10);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; tick(5);
         scl = 1'b1;   tick(10);
         scl = 1'b0;
         if (i > 0) tick(5);
      end
      m_sda = 1'b1;
      ack_lat = 0;
      for (int k = 1; k <= 10; k++) begin
         tick(1);
         if (sda_pull && ack_lat == 0) ack_lat = k;
      end
      scl = 1'b1; tick(5);
      ack = !sda_bus; tick(5);
      scl = 1'b0; tick(10);
   endtask

   task automatic recv_byte(input bit mack, output logic [7:0] d);
      m_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         tick(5);
         scl = 1'b1; tick(5);
         d[i] = sda_bus; tick(5);
         scl = 1'b0; tick(5);
      end
      m_sda = mack ? 1'b0 : 1'b1; tick(5);
      scl = 1'b1; tick(10);
      scl = 1'b0; tick(5);
      m_sda = 1'b1;
   endtask

   task automatic t_reset();
      chk(sda_pull == 1'b0, "R10 reset release", int'(sda_pull), 0);
      chk(wr_en == 1'b0, "R10 reset no strobe", int'(wr_en), 0);
   endtask

   task automatic t_bad_code();
      bit a;
      int w0 = n_wr;
      bus_start();
      send_byte(8'hB6, a);
      chk(a == 1'b0, "R1 wrong code no ack", int'(a), 0);
      send_byte(8'hA0, a);
      chk(a == 1'b0, "R1 ignored until START", int'(a), 0);
      bus_stop();
      chk(n_wr == w0, "R1 no write after mismatch", n_wr - w0, 0);
   endtask

   task automatic t_byte_write();
      bit a;
      logic [7:0] d;
      int w0 = n_wr;
      bus_start();
      send_byte(8'hA6, a);
      chk(a == 1'b1, "R1 control ack", int'(a), 1);
      chk(ack_lat == HOLD + 1, "R9 drive delay after SCL fall", ack_lat, HOLD + 1);
      send_byte(8'h45, a);
      chk(a == 1'b1, "R3 address ack", int'(a), 1);
      send_byte(8'h5A, a);
      chk(a == 1'b1, "R3 data ack", int'(a), 1);
      send_byte(8'hC3, a);
      send_byte(8'h81, a);
      bus_stop();
      chk(mem[11'h345] == 8'h5A, "R2 block bits form address top", int'(mem[11'h345]), 'h5A);
      chk(mem[11'h346] == 8'hC3, "R3 second data byte", int'(mem[11'h346]), 'hC3);
      chk(mem[11'h347] == 8'h81, "R3 third data byte", int'(mem[11'h347]), 'h81);
      chk(n_wr - w0 == 3, "R3 strobe count", n_wr - w0, 3);
      // current-address read continues after the last written byte
      bus_start();
      send_byte(8'hA7, a);
      recv_byte(1'b0, d);
      bus_stop();
      chk(d == pat(11'h348), "R5 current address read", int'(d), int'(pat(11'h348)));
   endtask

   task automatic t_busy();
      bit a;
      int w0;
      busy = 1'b1;
      bus_start();
      send_byte(8'hA0, a);
      bus_stop();
      chk(a == 1'b0, "R4 busy control nack", int'(a), 0);
      busy = 1'b0;
      bus_start();
      send_byte(8'hA0, a);
      chk(a == 1'b1, "R4 poll ack after busy", int'(a), 1);
      send_byte(8'h20, a);
      busy = 1'b1;
      w0 = n_wr;
      send_byte(8'h77, a);
      bus_stop();
      busy = 1'b0;
      chk(a == 1'b0, "R4 busy data nack", int'(a), 0);
      chk(n_wr == w0, "R4 no strobe while busy", n_wr - w0, 0);
      chk(mem[11'h020] == pat(11'h020), "R4 memory untouched", int'(mem[11'h020]), int'(pat(11'h020)));
   endtask

   task automatic t_random_read();
      bit a;
      logic [7:0] d;
      bus_start();
      send_byte(8'hAA, a);
      send_byte(8'h10, a);
      bus_start();
      send_byte(8'hAB, a);
      chk(a == 1'b1, "R1 read control ack", int'(a), 1);
      recv_byte(1'b0, d);
      chk(d == pat(11'h510), "R6 random read data, R9 MSB first", int'(d), int'(pat(11'h510)));
      chk(sda_pull == 1'b0, "R7 released after master nack", int'(sda_pull), 0);
      recv_byte(1'b0, d);
      chk(d == 8'hFF, "R7 no drive after nack", int'(d), 'hFF);
      bus_stop();
      bus_start();
      send_byte(8'hAB, a);
      recv_byte(1'b0, d);
      bus_stop();
      chk(d == pat(11'h511), "R5 current read after random read", int'(d), int'(pat(11'h511)));
   endtask

   task automatic t_seq_wrap();
      bit a;
      logic [7:0] d;
      bus_start();
      send_byte(8'hAE, a);
      send_byte(8'hFE, a);
      bus_start();
      send_byte(8'hAF, a);
      for (int j = 0; j < 4; j++) begin
         int exp_a = (16'h7FE + j) & 16'h7FF;
         recv_byte(j < 3, d);
         chk(d == pat(exp_a), j < 2 ? "R7 sequential read" : "R8 wrap past top",
             int'(d), int'(pat(exp_a)));
      end
      bus_stop();
   endtask

   task automatic t_stop_abort();
      bit a;
      bus_start();
      send_byte(8'hA0, a);
      for (int i = 0; i < 3; i++) begin
         m_sda = 1'b1; tick(5);
         scl = 1'b1;   tick(10);
         scl = 1'b0;   tick(5);
      end
      bus_stop();
      chk(sda_pull == 1'b0, "R10 stop releases", int'(sda_pull), 0);
      send_byte(8'hA0, a);
      chk(a == 1'b0, "R10 idle after mid-byte stop", int'(a), 0);
   endtask

   initial begin
      for (int i = 0; i < 2048; i++) mem[i] = pat(i);
      tick(4);
      rst_n = 1'b1;
      tick(4);
      t_reset();
      t_bad_code();
      t_byte_write();
      t_busy();
      t_random_read();
      t_seq_wrap();
      t_stop_abort();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual 0x0 expected 0x1");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule